// File: doc/BRIEF.md
# Grouped-Channel Dual-Edge Hit Recorder and Event Framer

The block watches a set of discriminated timing channels, each channel being the logical OR of a group of detector strips. While its capture window is open, it stamps the rising and falling edge of every pulse with a 16-bit window time. Each channel has four hit slots. A trigger closes the window. On that trigger the block latches the strip hit pattern, a 64-bit timestamp and a detector identifier, assigns an event number, and sends the finished record as a stream of 32-bit words with a valid/ready handshake.

Once the last word of a record is accepted, the slots are emptied and the window time restarts, so the next event begins from a clean state. Capture stays frozen while a record is being sent. A trigger that arrives during that time is refused and counted. Fine interpolation of edge times and any network transport sit outside the block.

The record has 73 words:
- words 0 to 3: the header;
- words 4 to 7: the strip pattern;
- words 8 to 71: one timing word per hit slot;
- word 72: a status word holding the overflow flags and the refused-trigger count.

Top module: `edge_event_packer`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is low and remains low until a trigger is accepted.
- R2: A trigger seen while `out_valid` is low is accepted. `out_valid` rises on the following cycle. Exactly 73 words are transferred, `out_last` is high only with the 73rd, and `out_valid` is low in the cycle after that word is accepted.
- R3: Words 0 to 3 are the values held at the accepting clock edge: `det_id`, then the event number, then `ts_in[63:32]`, then `ts_in[31:0]`. Later changes to these inputs do not alter the record.
- R4: Word 4+k carries `strip_in[32k+31:32k]` for k = 0 to 3, latched at the accepting edge.
- R5: Word 8+4c+h describes hit h (counted in arrival order) of channel c. Bits [31:16] hold the rising-edge time and bits [15:0] hold the falling-edge time.
- R6: The window time is 0 in the first cycle after reset ends, and again in the first cycle after the last word of a record is accepted. It then rises by one per cycle and saturates at 16'hFFFE. An edge is stamped with the window time of the cycle in which the channel input is sampled changed.
- R7: A slot that received no edge reads 16'hFFFF in that half. A hit whose falling edge has not arrived by the trigger keeps its rising time and reads 16'hFFFF as its falling time.
- R8: A falling edge on a channel that has no open rising edge in the current window (for example, a channel already high when the window opened) changes nothing in the record.
- R9: A fifth or later rising edge on a channel within one window is dropped. It sets bit c of status word 72 (bits [15:0], one per channel), and the four stored hits are unchanged.
- R10: The first accepted trigger after reset carries event number 0. Each later accepted trigger carries the previous number plus one. Refused triggers do not advance it.
- R11: A trigger seen while `out_valid` is high is refused and leaves the record being sent intact. Status bits [31:16] of each record give the number of refused triggers since reset, as counted at that record's accepting edge, saturating at 16'hFFFF.
- R12: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values.
- R13: After a record is sent, every slot is empty again and every overflow flag is clear for the next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_in | input | 16 | Discriminated grouped-strip channel levels, synchronous to clk |
| strip_in | input | 128 | Strip hit pattern, one bit per strip |
| trig | input | 1 | Trigger request, sampled each cycle |
| det_id | input | 32 | Detector identifier written into the header |
| ts_in | input | 64 | Running timestamp latched on an accepted trigger |
| out_ready | input | 1 | Downstream can take a word |
| out_valid | output | 1 | A record word is presented |
| out_data | output | 32 | Record word |
| out_last | output | 1 | Marks the final (status) word |

## Verification
If a channel's slot pointer or open-edge flag is wrong, the error appears as misplaced or missing edge times in words 8 to 71 of the very next record. If the window time base restarts at the wrong moment, every edge stamp is shifted by a constant, which the exact per-cycle expected times expose. A wrong word index shows up at once as `out_last` on the wrong beat or as a record of the wrong length. Stale slots or overflow flags only become visible one event later, which is why events are sent back to back with a deliberately empty channel.

// File: rtl/eep_pkg.sv
// Shared constants and types for the edge event packer.
// Assumes a 32-bit output word made of two 16-bit edge times.
package eep_pkg;
    localparam int WORD_W    = 32;
    localparam int EDGE_W    = WORD_W / 2;
    localparam int HDR_WORDS = 4;

    typedef enum logic [1:0] {
        SEC_HDR  = 2'd0,
        SEC_PAT  = 2'd1,
        SEC_TIME = 2'd2,
        SEC_STAT = 2'd3
    } rec_sec_t;
endpackage

// File: rtl/eep_chan_capture.sv
// Per-channel dual-edge capture with HITS slots.
// Stores the rising time when a slot is free and the falling time for an
// open hit. Counts a rising edge with no free slot as overflow. A falling
// edge with no open hit is dropped. Assumes sig is synchronous and HITS >= 2.
module eep_chan_capture #(
    parameter int HITS = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clr,
    input  logic                             en,
    input  logic                             sig,
    input  logic [eep_pkg::EDGE_W-1:0]       tnow,
    output logic [HITS*eep_pkg::EDGE_W-1:0]  lead_o,
    output logic [HITS*eep_pkg::EDGE_W-1:0]  trail_o,
    output logic                             ovf_o
);
    import eep_pkg::*;
    localparam int CW = $clog2(HITS + 1);
    localparam int IW = $clog2(HITS);
    localparam logic [EDGE_W-1:0] EMPTY = '1;

    logic              prev_q;
    logic              open_q;
    logic [CW-1:0]     cnt_q;
    logic [EDGE_W-1:0] lead_q  [HITS];
    logic [EDGE_W-1:0] trail_q [HITS];
    logic              rise, fall;

    assign rise = sig & ~prev_q;
    assign fall = ~sig & prev_q;

    // Track the previous level, even while capture is frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig;
    end

    // Fill slots in arrival order; empty all of them on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q  <= '0;
            open_q <= 1'b0;
            ovf_o  <= 1'b0;
            for (int i = 0; i < HITS; i++) begin
                lead_q[i]  <= EMPTY;
                trail_q[i] <= EMPTY;
            end
        end else if (en) begin
            if (rise) begin
                if (cnt_q == CW'(HITS)) begin
                    ovf_o <= 1'b1;
                end else begin
                    lead_q[cnt_q[IW-1:0]] <= tnow;
                    open_q <= 1'b1;
                end
            end else if (fall && open_q) begin
                trail_q[cnt_q[IW-1:0]] <= tnow;
                cnt_q  <= cnt_q + 1'b1;
                open_q <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < HITS; g++) begin : g_flat
        assign lead_o[g*EDGE_W +: EDGE_W]  = lead_q[g];
        assign trail_o[g*EDGE_W +: EDGE_W] = trail_q[g];
    end
endmodule

// File: rtl/eep_framer.sv
// Record serializer: header, strip pattern, timing words, status word.
// Assumes start is only pulsed while out_valid is low, and that the inputs
// stay stable for the whole record.
module eep_framer #(
    parameter int NCH    = 16,
    parameter int HITS   = 4,
    parameter int STRIPS = 128
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start,
    input  logic [eep_pkg::WORD_W-1:0]           id_i,
    input  logic [eep_pkg::WORD_W-1:0]           evt_i,
    input  logic [2*eep_pkg::WORD_W-1:0]         ts_i,
    input  logic [STRIPS-1:0]                    pat_i,
    input  logic [NCH*HITS*eep_pkg::EDGE_W-1:0]  lead_i,
    input  logic [NCH*HITS*eep_pkg::EDGE_W-1:0]  trail_i,
    input  logic [eep_pkg::WORD_W-1:0]           status_i,
    input  logic                                 out_ready,
    output logic                                 out_valid,
    output logic [eep_pkg::WORD_W-1:0]           out_data,
    output logic                                 out_last
);
    import eep_pkg::*;
    localparam int PW = STRIPS / WORD_W;
    localparam int NT = NCH * HITS;
    localparam int NW = HDR_WORDS + PW + NT + 1;
    localparam int IW = $clog2(NW);

    logic [IW-1:0] idx_q;
    rec_sec_t      sec;
    int            ix;

    // Step through word indices while the receiver accepts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            idx_q     <= '0;
        end else if (start) begin
            out_valid <= 1'b1;
            idx_q     <= '0;
        end else if (out_valid && out_ready) begin
            if (idx_q == IW'(NW - 1)) out_valid <= 1'b0;
            else                      idx_q     <= idx_q + 1'b1;
        end
    end

    // Decode the index into a section and select the word.
    always_comb begin
        ix = int'(idx_q);
        if (ix < HDR_WORDS)                sec = SEC_HDR;
        else if (ix < HDR_WORDS + PW)      sec = SEC_PAT;
        else if (ix < HDR_WORDS + PW + NT) sec = SEC_TIME;
        else                               sec = SEC_STAT;
        out_data = '0;
        case (sec)
            SEC_HDR: begin
                case (idx_q[1:0])
                    2'd0:    out_data = id_i;
                    2'd1:    out_data = evt_i;
                    2'd2:    out_data = ts_i[2*WORD_W-1:WORD_W];
                    default: out_data = ts_i[WORD_W-1:0];
                endcase
            end
            SEC_PAT:  out_data = pat_i[(ix - HDR_WORDS)*WORD_W +: WORD_W];
            SEC_TIME: out_data = {lead_i[(ix - HDR_WORDS - PW)*EDGE_W +: EDGE_W],
                                  trail_i[(ix - HDR_WORDS - PW)*EDGE_W +: EDGE_W]};
            default:  out_data = status_i;
        endcase
    end

    assign out_last = out_valid && (idx_q == IW'(NW - 1));
endmodule

// File: rtl/edge_event_packer.sv
// Top level: window time base, trigger acceptance, event latches, the
// channel capture array and the record framer.
// Assumes that chan_in and trig are synchronous to clk, NCH <= 16, and
// that STRIPS is a multiple of 32.
module edge_event_packer #(
    parameter int NCH    = 16,
    parameter int HITS   = 4,
    parameter int STRIPS = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    chan_in,
    input  logic [STRIPS-1:0] strip_in,
    input  logic              trig,
    input  logic [31:0]       det_id,
    input  logic [63:0]       ts_in,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [31:0]       out_data,
    output logic              out_last
);
    import eep_pkg::*;
    localparam int RW = WORD_W - NCH;
    localparam int SW = HITS * EDGE_W;
    localparam logic [EDGE_W-1:0] T_MAX = {{(EDGE_W-1){1'b1}}, 1'b0};

    logic                     accept, rec_done;
    logic [EDGE_W-1:0]        tnow_q;
    logic [WORD_W-1:0]        evt_next_q, evt_q, id_q;
    logic [63:0]              ts_q;
    logic [STRIPS-1:0]        pat_q;
    logic [RW-1:0]            rej_q, rej_snap_q;
    logic [NCH*SW-1:0]        lead_all, trail_all;
    logic [NCH-1:0]           ovf_all;

    assign accept   = trig && !out_valid;
    assign rec_done = out_valid && out_ready && out_last;

    // Window time: restart after a record, saturate, hold while sending.
    always_ff @(posedge clk) begin
        if (!rst_n || rec_done)               tnow_q <= '0;
        else if (!out_valid && tnow_q != T_MAX) tnow_q <= tnow_q + 1'b1;
    end

    // Latch the event fields and assign the event number on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_next_q <= '0;
            evt_q      <= '0;
            id_q       <= '0;
            ts_q       <= '0;
            pat_q      <= '0;
            rej_snap_q <= '0;
        end else if (accept) begin
            evt_q      <= evt_next_q;
            evt_next_q <= evt_next_q + 1'b1;
            id_q       <= det_id;
            ts_q       <= ts_in;
            pat_q      <= strip_in;
            rej_snap_q <= rej_q;
        end
    end

    // Count triggers refused while a record is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)                                rej_q <= '0;
        else if (trig && out_valid && rej_q != '1) rej_q <= rej_q + 1'b1;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        eep_chan_capture #(.HITS(HITS)) u_cap (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (rec_done),
            .en      (!out_valid),
            .sig     (chan_in[c]),
            .tnow    (tnow_q),
            .lead_o  (lead_all[c*SW +: SW]),
            .trail_o (trail_all[c*SW +: SW]),
            .ovf_o   (ovf_all[c])
        );
    end

    eep_framer #(.NCH(NCH), .HITS(HITS), .STRIPS(STRIPS)) u_frm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .id_i      (id_q),
        .evt_i     (evt_q),
        .ts_i      (ts_q),
        .pat_i     (pat_q),
        .lead_i    (lead_all),
        .trail_i   (trail_all),
        .status_i  ({rej_snap_q, ovf_all}),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );
endmodule

// File: rtl/eep_checker.sv
// Protocol checks on the packer's output stream, bound to the top module.
// Keeps its own count of accepted words in the current record.
module eep_checker #(
    parameter int NCH    = 16,
    parameter int HITS   = 4,
    parameter int STRIPS = 128
) (
    input logic        clk,
    input logic        rst_n,
    input logic        trig,
    input logic        out_valid,
    input logic        out_ready,
    input logic        out_last,
    input logic [31:0] out_data
);
    localparam int NW = 4 + STRIPS / 32 + NCH * HITS + 1;
    localparam int CW = $clog2(NW);

    logic [CW-1:0] wcnt;

    // Count words accepted since the start of the current record.
    always_ff @(posedge clk) begin
        if (!rst_n)                      wcnt <= '0;
        else if (out_valid && out_ready) wcnt <= out_last ? '0 : wcnt + 1'b1;
    end

    // R12
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R2
    last_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_last == (wcnt == CW'(NW - 1))));

    // R2
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid);

    // R2
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !out_valid) |=> out_valid);
endmodule

bind edge_event_packer eep_checker #(.NCH(NCH), .HITS(HITS), .STRIPS(STRIPS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_last  (out_last),
    .out_data  (out_data)
);

// File: tb/sim_edge_event_packer.sv
`timescale 1ns/1ps
// Directed bench: each task drives one scenario and checks its own results.
module sim_edge_event_packer;
    localparam int NCH = 16, HITS = 4, STRIPS = 128, NW = 73;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    chan_in = '0;
    logic [STRIPS-1:0] strip_in = '0;
    logic              trig = 1'b0;
    logic [31:0]       det_id = '0;
    logic [63:0]       ts_in = '0;
    logic              ready = 1'b0;
    logic              out_valid, out_last;
    logic [31:0]       out_data;

    always #2.5 clk = ~clk;

    edge_event_packer #(.NCH(NCH), .HITS(HITS), .STRIPS(STRIPS)) u0 (
        .clk(clk), .rst_n(rst_n), .chan_in(chan_in), .strip_in(strip_in),
        .trig(trig), .det_id(det_id), .ts_in(ts_in), .out_ready(ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
    );

    int pos = 0;
    always @(posedge clk) pos++;

    int total = 0, bad = 0, win0 = 0, evt_exp = 0, rej_exp = 0;
    logic [15:0] m_lead [NCH][HITS];
    logic [15:0] m_trail[NCH][HITS];
    int          m_cnt  [NCH];
    bit          m_open [NCH];
    bit          m_ovf  [NCH];
    logic [31:0] exp_w  [NW];
    logic [31:0] got    [NW];

    task automatic check(string req, logic [31:0] act, logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic int now_t();
        int t = pos + 1 - win0;
        return (t > 65534) ? 65534 : t;
    endfunction

    task automatic model_clear();
        for (int c = 0; c < NCH; c++) begin
            m_cnt[c] = 0; m_open[c] = 0; m_ovf[c] = 0;
            for (int h = 0; h < HITS; h++) begin
                m_lead[c][h] = 16'hFFFF; m_trail[c][h] = 16'hFFFF;
            end
        end
    endtask

    task automatic rise(int ch);
        @(negedge clk);
        chan_in[ch] = 1'b1;
        if (m_cnt[ch] < HITS) begin
            m_lead[ch][m_cnt[ch]] = 16'(now_t());
            m_open[ch] = 1;
        end else m_ovf[ch] = 1;
    endtask

    task automatic fall(int ch);
        @(negedge clk);
        chan_in[ch] = 1'b0;
        if (m_open[ch]) begin
            m_trail[ch][m_cnt[ch]] = 16'(now_t());
            m_cnt[ch]++;
            m_open[ch] = 0;
        end
    endtask

    task automatic pulse(int ch, int w);
        rise(ch);
        repeat (w - 1) @(negedge clk);
        fall(ch);
    endtask

    function automatic string tag(int i);
        if (i == 1) return "R10 word";
        if (i < 4)  return "R3 word";
        if (i < 8)  return "R4 word";
        if (i < 72) return "R5/R7 word";
        return "R9/R11 word";
    endfunction

    // Present a trigger, build the expected record, then scramble inputs (R3).
    task automatic fire(logic [31:0] id, logic [63:0] ts, logic [127:0] pat);
        logic [15:0] ov;
        @(negedge clk);
        det_id = id; ts_in = ts; strip_in = pat; trig = 1'b1;
        exp_w[0] = id; exp_w[1] = evt_exp; exp_w[2] = ts[63:32]; exp_w[3] = ts[31:0];
        for (int k = 0; k < 4; k++) exp_w[4+k] = pat[32*k +: 32];
        ov = '0;
        for (int c = 0; c < NCH; c++) begin
            ov[c] = m_ovf[c];
            for (int h = 0; h < HITS; h++) exp_w[8+c*HITS+h] = {m_lead[c][h], m_trail[c][h]};
        end
        exp_w[72] = {16'(rej_exp), ov};
        @(negedge clk);
        trig = 1'b0; det_id = ~id; ts_in = ~ts; strip_in = ~pat;
        check("R2 valid after trigger", 32'(out_valid), 32'd1);
        evt_exp++;
    endtask

    // Collect one record, optionally with stalls and a refused trigger.
    task automatic drain(bit stall, bit poke);
        int k = 0;
        int guard = 0;
        bit hold = 0;
        bit tg = 0;
        logic [31:0] hd = '0;
        if (poke) begin
            @(negedge clk); trig = 1'b1;
            @(negedge clk); trig = 1'b0;
            rej_exp++;
            check("R11 record continues", 32'(out_valid), 32'd1);
        end
        while (k < NW && guard < 1000) begin
            @(negedge clk);
            guard++;
            if (hold) check("R12 data held", out_data, hd);
            hold = 0;
            tg = ~tg;
            ready = stall ? tg : 1'b1;
            if (out_valid && ready) begin
                got[k] = out_data;
                check("R2 last flag", 32'(out_last), 32'(k == NW - 1));
                k++;
                if (k == NW) win0 = pos + 2;
            end else if (out_valid) begin
                hold = 1; hd = out_data;
            end
        end
        check("R2 word count", k, NW);
        @(negedge clk);
        ready = 1'b0;
        check("R2 valid ends", 32'(out_valid), 32'd0);
        for (int i = 0; i < NW; i++) check(tag(i), got[i], exp_w[i]);
        model_clear();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 idle in reset", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        win0 = pos + 1;
        model_clear();
        repeat (3) @(negedge clk);
        check("R1 idle after reset", 32'(out_valid), 32'd0);
    endtask

    task automatic t_basic();
        pulse(0, 3);
        pulse(5, 1);
        pulse(15, 2);
        repeat (2) @(negedge clk);
        pulse(15, 4);
        repeat (3) @(negedge clk);
        fire(32'hA5A5_0001, 64'h0123_4567_89AB_CDEF,
             128'hDEAD_BEEF_0000_FFFF_1234_5678_CAFE_F00D);
        drain(1'b0, 1'b0);
        check("R10 first event", got[1], 32'd0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 6; i++) begin
            pulse(2, 1);
            @(negedge clk);
        end
        rise(9);
        repeat (2) @(negedge clk);
        fire(32'h0000_0B0B, 64'hFFFF_0000_FFFF_0001, 128'h1);
        drain(1'b1, 1'b1);
        check("R9 overflow flag ch2", 32'(got[72][2]), 32'd1);
        check("R7 open hit trail", 32'(got[8+9*HITS][15:0]), 32'h0000_FFFF);
    endtask

    task automatic t_fresh();
        repeat (3) @(negedge clk);
        fall(9);
        pulse(4, 2);
        fire(32'h1357_9BDF, 64'h0000_0001_0000_0002, 128'h8000_0000_0000_0000_0000_0000_0000_0000);
        drain(1'b0, 1'b0);
        check("R13 slots emptied", got[8+2*HITS], 32'hFFFF_FFFF);
        check("R13 overflow cleared", 32'(got[72][2]), 32'd0);
        check("R8 lone fall ignored", got[8+9*HITS], 32'hFFFF_FFFF);
        check("R11 refused count", 32'(got[72][31:16]), 32'd1);
        check("R10 third event", got[1], 32'd2);
    endtask

    task automatic t_saturate();
        repeat (65540) @(negedge clk);
        pulse(3, 2);
        fire(32'h5A5A_5A5A, 64'h7, 128'h0);
        drain(1'b0, 1'b0);
        check("R6 saturated time", got[8+3*HITS], 32'hFFFE_FFFE);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_overflow();
        t_fresh();
        t_saturate();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule